// File: doc/BRIEF.md
# Transmit descriptor ring reader

This block walks a ring of transmit descriptors in a shared word-wide memory and turns the buffers they point at into a byte stream. Each descriptor takes two consecutive words: a byte address of the buffer, then a control word. A start pulse wakes the walker at its current ring position. For each descriptor that software has handed over, the walker fetches the buffer, sends its bytes downstream, and then rewrites the control word with the ownership flag set. It stops when it reaches a descriptor that software has not handed over. A halt pulse lets the frame in progress finish and then parks the walker.

The memory port is a plain single-port interface. A request (`mem_en`) with `mem_we` low returns `mem_rdata` on the next clock edge. A request with `mem_we` high writes the word on that edge. The port never stalls. The byte output is a valid/ready stream. Once `tx_valid` is high, it stays high and `tx_data`, `tx_last`, `tx_err` and `tx_nocrc` hold their values until a cycle in which `tx_ready` is high. A beat is transferred on any clock edge where both `tx_valid` and `tx_ready` are high, and `tx_ready` may stay low for any number of cycles. Retransmission and checksum generation are not part of the block. Only the request not to append a checksum is forwarded as a sideband.

Top module: `txdesc_ring_reader`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next clock edge. A `start` pulse while busy has no effect on the stream, the memory writes or the ring position.
- R2: Descriptor i sits at word `ring_base + 2*i`. That word holds the buffer byte address, and the next word holds the control word. Control fields: bit 31 = owned by software (used), bit 30 = last descriptor of the ring, bit 28 = underrun report, bit 27 = ran out of buffers mid-frame, bit 16 = send without checksum, bit 15 = last buffer of the frame, bits 10:0 = buffer length in bytes.
- R3: Buffer bytes are sent in address order starting at the buffer byte address. Memory words are little-endian (byte lane 0 = bits 7:0). `tx_last` is high only on the final byte of a buffer whose bit 15 is set.
- R4: While `tx_valid` is high and `tx_ready` is low, the next cycle keeps `tx_valid` high and all beat fields unchanged.
- R5: After the last byte of a buffer has been accepted, the control word of that descriptor is rewritten with bit 31 set, bits 28 and 27 cleared, and all other bits unchanged. No byte of the next buffer is sent before this write.
- R6: After a descriptor with bit 30 set, the next descriptor read is descriptor 0. Otherwise it is the following index.
- R7: If the walker meets a descriptor with bit 31 set between frames, it stops and drops `busy` without writing memory. It keeps that position, so the next `start` rereads that descriptor first.
- R8: If the walker meets a descriptor with bit 31 set inside a frame, it sends one terminating beat with data 0x00, `tx_last`=1 and `tx_err`=1. It then rewrites the control word of the frame's first descriptor as its original value with bits 31 and 27 set, and stops at the used descriptor.
- R9: A `halt` pulse while busy lets the current frame complete, including its write-backs. The walker then stops before reading the next descriptor. The next `start` resumes at that descriptor.
- R10: `tx_nocrc` equals bit 16 of the first descriptor of the current frame on every beat of that frame.
- R11: A zero-length buffer sends no bytes. If it ends a frame, a single beat with data 0x00, `tx_last`=1 and `tx_err`=0 closes the frame.
- R12: After reset, `busy`, `tx_valid` and `mem_en` are low and the ring position is descriptor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: begin walking the ring |
| halt | input | 1 | Pulse: stop after the current frame |
| ring_base | input | AW | Word address of descriptor 0 |
| busy | output | 1 | Walker active |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Byte beat valid |
| tx_ready | input | 1 | Downstream accepts the beat |
| tx_data | output | 8 | Byte |
| tx_last | output | 1 | Final beat of a frame |
| tx_err | output | 1 | Frame ended because buffers ran out |
| tx_nocrc | output | 1 | Frame is to be sent without checksum |

## Verification
The assertions check the following on every cycle:
- beats are held stable under back-pressure;
- the pump is never launched while it is still busy;
- no write-back overlaps a pending beat;
- the walker and the pump never both drive the memory port;
- an idle walker drives neither the stream nor the memory;
- `busy` never falls inside a frame.

Only the bench scenarios can show the following:
- byte order from unaligned addresses;
- the exact write-back values;
- wrapping to descriptor 0 and where the walker resumes after a stop;
- the terminating beats for exhausted and zero-length frames;
- the frame boundary at which a halt takes effect.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int unsigned TXD_USED  = 31;
  localparam int unsigned TXD_WRAP  = 30;
  localparam int unsigned TXD_UNDR  = 28;
  localparam int unsigned TXD_EXH   = 27;
  localparam int unsigned TXD_NOCRC = 16;
  localparam int unsigned TXD_EOF   = 15;

  typedef enum logic [2:0] {
    C_IDLE, C_RD_CTRL, C_WT_CTRL, C_WT_ADDR, C_PUMP, C_WB, C_TERM, C_WB_EXH
  } walk_state_e;

  typedef enum logic [2:0] {
    P_IDLE, P_RD, P_WAIT, P_EMIT, P_TERM
  } pump_state_e;
endpackage

// File: rtl/txr_byte_pump.sv
module txr_byte_pump
  import txr_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LENW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic            term_i,
  input  logic            err_i,
  input  logic [31:0]     addr_i,
  input  logic [LENW-1:0] len_i,
  input  logic            eof_i,
  output logic            busy_o,
  output logic            rd_en_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic [31:0]     rd_data_i,
  output logic            tx_valid_o,
  input  logic            tx_ready_i,
  output logic [7:0]      tx_data_o,
  output logic            tx_last_o,
  output logic            tx_err_o
);
  pump_state_e     st_q;
  logic [31:0]     ptr_q;
  logic [LENW-1:0] rem_q;
  logic [31:0]     word_q;
  logic            eof_q;
  logic            err_q;
  logic            fire;

  assign busy_o    = (st_q != P_IDLE);
  assign rd_en_o   = (st_q == P_RD);
  assign rd_addr_o = ptr_q[AW+1:2];
  assign fire      = tx_valid_o && tx_ready_i;

  always_comb begin
    tx_valid_o = 1'b0;
    tx_data_o  = 8'h00;
    tx_last_o  = 1'b0;
    tx_err_o   = 1'b0;
    if (st_q == P_EMIT) begin
      tx_valid_o = 1'b1;
      tx_data_o  = 8'(word_q >> {ptr_q[1:0], 3'b000});
      tx_last_o  = eof_q && (rem_q == LENW'(1));
    end else if (st_q == P_TERM) begin
      tx_valid_o = 1'b1;
      tx_last_o  = 1'b1;
      tx_err_o   = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      ptr_q  <= '0;
      rem_q  <= '0;
      word_q <= '0;
      eof_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        P_IDLE: if (go_i) begin
          if (term_i || (len_i == '0 && eof_i)) begin
            st_q  <= P_TERM;
            err_q <= term_i && err_i;
          end else if (len_i != '0) begin
            ptr_q <= addr_i;
            rem_q <= len_i;
            eof_q <= eof_i;
            st_q  <= P_RD;
          end
        end
        P_RD:   st_q <= P_WAIT;
        P_WAIT: begin
          word_q <= rd_data_i;
          st_q   <= P_EMIT;
        end
        P_EMIT: if (fire) begin
          ptr_q <= ptr_q + 32'd1;
          rem_q <= rem_q - LENW'(1);
          if (rem_q == LENW'(1))      st_q <= P_IDLE;
          else if (ptr_q[1:0] == 2'd3) st_q <= P_RD;
        end
        P_TERM: if (fire) st_q <= P_IDLE;
        default: st_q <= P_IDLE;
      endcase
    end
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) &&
                                     $stable(tx_last_o) && $stable(tx_err_o)));

  p_no_empty_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == P_EMIT) |-> (rem_q != '0));
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int AW   = 16,
  parameter int IDXW = 8,
  parameter int LENW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            halt_i,
  input  logic [AW-1:0]   ring_base_i,
  output logic            busy_o,
  output logic            mem_en_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic [31:0]     mem_rdata_i,
  output logic            pump_go_o,
  output logic            pump_term_o,
  output logic            pump_err_o,
  output logic [31:0]     pump_addr_o,
  output logic [LENW-1:0] pump_len_o,
  output logic            pump_eof_o,
  input  logic            pump_busy_i,
  output logic            nocrc_o
);
  walk_state_e     state_q;
  logic [IDXW-1:0] idx_q;
  logic [31:0]     ctrl_q;
  logic [31:0]     first_ctrl_q;
  logic [AW-1:0]   first_desc_q;
  logic            in_frame_q;
  logic            halt_pend_q;
  logic            nocrc_q;
  logic [AW-1:0]   desc_addr;
  logic [31:0]     wb_val;
  logic [31:0]     exh_val;
  logic            stop_now;

  assign desc_addr   = ring_base_i + AW'({idx_q, 1'b0});
  assign busy_o      = (state_q != C_IDLE);
  assign nocrc_o     = nocrc_q;
  assign pump_addr_o = mem_rdata_i;
  assign pump_len_o  = ctrl_q[LENW-1:0];
  assign pump_eof_o  = ctrl_q[TXD_EOF];
  assign stop_now    = !in_frame_q && halt_pend_q;

  always_comb begin
    wb_val           = ctrl_q;
    wb_val[TXD_USED] = 1'b1;
    wb_val[TXD_UNDR] = 1'b0;
    wb_val[TXD_EXH]  = 1'b0;
    exh_val           = first_ctrl_q;
    exh_val[TXD_USED] = 1'b1;
    exh_val[TXD_EXH]  = 1'b1;
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr + AW'(1);
    mem_wdata_o = '0;
    pump_go_o   = 1'b0;
    pump_term_o = 1'b0;
    pump_err_o  = 1'b0;
    case (state_q)
      C_RD_CTRL: mem_en_o = !stop_now;
      C_WT_CTRL: begin
        if (!mem_rdata_i[TXD_USED]) begin
          mem_en_o   = 1'b1;
          mem_addr_o = desc_addr;
        end else if (in_frame_q) begin
          pump_go_o   = 1'b1;
          pump_term_o = 1'b1;
          pump_err_o  = 1'b1;
        end
      end
      C_WT_ADDR: pump_go_o = 1'b1;
      C_WB: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = wb_val;
      end
      C_WB_EXH: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = first_desc_q + AW'(1);
        mem_wdata_o = exh_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= C_IDLE;
      idx_q        <= '0;
      ctrl_q       <= '0;
      first_ctrl_q <= '0;
      first_desc_q <= '0;
      in_frame_q   <= 1'b0;
      halt_pend_q  <= 1'b0;
      nocrc_q      <= 1'b0;
    end else begin
      if (state_q == C_IDLE) halt_pend_q <= 1'b0;
      else if (halt_i)       halt_pend_q <= 1'b1;
      case (state_q)
        C_IDLE:    if (start_i) state_q <= C_RD_CTRL;
        C_RD_CTRL: state_q <= stop_now ? C_IDLE : C_WT_CTRL;
        C_WT_CTRL: begin
          ctrl_q <= mem_rdata_i;
          if (mem_rdata_i[TXD_USED]) state_q <= in_frame_q ? C_TERM : C_IDLE;
          else                       state_q <= C_WT_ADDR;
        end
        C_WT_ADDR: begin
          if (!in_frame_q) begin
            first_ctrl_q <= ctrl_q;
            first_desc_q <= desc_addr;
            nocrc_q      <= ctrl_q[TXD_NOCRC];
          end
          state_q <= C_PUMP;
        end
        C_PUMP: if (!pump_busy_i) state_q <= C_WB;
        C_WB: begin
          in_frame_q <= !ctrl_q[TXD_EOF];
          idx_q      <= ctrl_q[TXD_WRAP] ? '0 : idx_q + IDXW'(1);
          state_q    <= C_RD_CTRL;
        end
        C_TERM: if (!pump_busy_i) state_q <= C_WB_EXH;
        C_WB_EXH: begin
          in_frame_q <= 1'b0;
          state_q    <= C_IDLE;
        end
        default: state_q <= C_IDLE;
      endcase
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == C_IDLE && start_i) |=> busy_o);

  p_stop_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !in_frame_q);

  p_go_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pump_go_o |-> !pump_busy_i);
endmodule

// File: rtl/txr_mem_mux.sv
module txr_mem_mux #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w_en_i,
  input  logic          w_we_i,
  input  logic [AW-1:0] w_addr_i,
  input  logic [31:0]   w_wdata_i,
  input  logic          p_en_i,
  input  logic [AW-1:0] p_addr_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o
);
  assign mem_en_o    = w_en_i || p_en_i;
  assign mem_we_o    = w_en_i && w_we_i;
  assign mem_addr_o  = p_en_i ? p_addr_i : w_addr_i;
  assign mem_wdata_o = w_wdata_i;

  p_port_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_en_i && p_en_i));
endmodule

// File: rtl/txdesc_ring_reader.sv
module txdesc_ring_reader
  import txr_pkg::*;
#(
  parameter int AW   = 16,
  parameter int IDXW = 8,
  parameter int LENW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          halt,
  input  logic [AW-1:0] ring_base,
  output logic          busy,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_err,
  output logic          tx_nocrc
);
  logic            w_en, w_we;
  logic [AW-1:0]   w_addr;
  logic [31:0]     w_wdata;
  logic            p_en;
  logic [AW-1:0]   p_addr;
  logic            go, term, err, eof, pbusy;
  logic [31:0]     paddr;
  logic [LENW-1:0] plen;

  txr_walker #(.AW(AW), .IDXW(IDXW), .LENW(LENW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(start), .halt_i(halt),
    .ring_base_i(ring_base), .busy_o(busy),
    .mem_en_o(w_en), .mem_we_o(w_we), .mem_addr_o(w_addr),
    .mem_wdata_o(w_wdata), .mem_rdata_i(mem_rdata),
    .pump_go_o(go), .pump_term_o(term), .pump_err_o(err),
    .pump_addr_o(paddr), .pump_len_o(plen), .pump_eof_o(eof),
    .pump_busy_i(pbusy), .nocrc_o(tx_nocrc)
  );

  txr_byte_pump #(.AW(AW), .LENW(LENW)) u_pump (
    .clk(clk), .rst_n(rst_n), .go_i(go), .term_i(term), .err_i(err),
    .addr_i(paddr), .len_i(plen), .eof_i(eof), .busy_o(pbusy),
    .rd_en_o(p_en), .rd_addr_o(p_addr), .rd_data_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_err_o(tx_err)
  );

  txr_mem_mux #(.AW(AW)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .w_en_i(w_en), .w_we_i(w_we), .w_addr_i(w_addr), .w_wdata_i(w_wdata),
    .p_en_i(p_en), .p_addr_i(p_addr),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata)
  );

  p_wb_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !tx_valid);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_valid && !mem_en));
endmodule

// File: tb/txdesc_ring_reader_bench.sv
module txdesc_ring_reader_bench;
  localparam int AW = 16;
  localparam int BASE = 'h40;
  localparam logic [31:0] USED = 32'h8000_0000;
  localparam logic [31:0] WRAP = 32'h4000_0000;
  localparam logic [31:0] UNDR = 32'h1000_0000;
  localparam logic [31:0] EXH  = 32'h0800_0000;
  localparam logic [31:0] NOCRC = 32'h0001_0000;
  localparam logic [31:0] EOF  = 32'h0000_8000;

  logic clk = 0, rst_n = 0, start = 0, halt = 0;
  logic [AW-1:0] ring_base = AW'(BASE);
  logic busy, mem_en, mem_we, tx_valid, tx_last, tx_err, tx_nocrc;
  logic tx_ready = 1;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] tx_data;

  logic [31:0] mem [0:1023];
  logic [31:0] mm  [0:1023];
  logic sw_we = 0;
  logic [9:0] sw_a;
  logic [31:0] sw_d;

  logic [10:0] exp_beat[$];
  int          exp_wa[$];
  logic [31:0] exp_wd[$];
  int errors = 0, checks = 0, cyc = 0, cur_idx = 0;
  string run_tag = "R12";
  bit rand_rdy = 0, halt_arm = 0, halt_go = 0, prev_hold = 0, done = 0;
  logic [10:0] prev_beat;

  txdesc_ring_reader u_txdesc_ring_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
    .ring_base(ring_base), .busy(busy), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_err(tx_err), .tx_nocrc(tx_nocrc)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (sw_we) mem[sw_a] <= sw_d;
    else if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    else if (mem_en) mem_rdata <= mem[mem_addr[9:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    logic [10:0] got;
    halt = halt_go;
    halt_go = 0;
    tx_ready = rand_rdy ? (($urandom % 4) != 0) : 1'b1;
    #1;
    if (rst_n) begin
      got = {tx_data, tx_last, tx_err, tx_nocrc};
      if (prev_hold)
        chk(tx_valid && got == prev_beat, "R4", "held beat",
            {20'd0, tx_valid, got}, {20'd0, 1'b1, prev_beat});
      prev_hold = tx_valid && !tx_ready;
      prev_beat = got;
      if (tx_valid && tx_ready) begin
        if (exp_beat.size() == 0)
          chk(0, {run_tag, " R3"}, "unexpected beat", {21'd0, got}, 32'd0);
        else begin
          chk(got == exp_beat[0], {run_tag, " R3 R10"}, "beat",
              {21'd0, got}, {21'd0, exp_beat[0]});
          void'(exp_beat.pop_front());
          if (halt_arm) begin halt_arm = 0; halt_go = 1; end
        end
      end
      if (mem_en && mem_we) begin
        if (exp_wa.size() == 0)
          chk(0, {run_tag, " R5"}, "unexpected write", {16'd0, mem_addr}, 32'd0);
        else begin
          chk(mem_addr == AW'(exp_wa[0]), {run_tag, " R2"}, "write addr",
              {16'd0, mem_addr}, exp_wa[0]);
          chk(mem_wdata == exp_wd[0], {run_tag, " R5"}, "write data",
              mem_wdata, exp_wd[0]);
          void'(exp_wa.pop_front());
          void'(exp_wd.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog %s: actual=hung expected=finished", run_tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1; sw_a = 10'(a); sw_d = d;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic desc(input int i, input logic [31:0] a, input logic [31:0] c);
    poke(BASE + 2 * i, a);
    poke(BASE + 2 * i + 1, c);
  endtask

  task automatic model(input int sidx, input int maxf, output int eidx);
    int idx, frames, fdesc, d, len, b;
    bit inf, nc;
    logic [31:0] c, a, fctrl, w, wd;
    idx = sidx; frames = 0; inf = 0; nc = 0; fdesc = 0; fctrl = 0;
    for (int k = 0; k < 1024; k++) mm[k] = mem[k];
    forever begin
      if (!inf && frames >= maxf) break;
      d = BASE + 2 * idx;
      c = mm[d + 1];
      if (c[31]) begin
        if (inf) begin
          exp_beat.push_back({8'h00, 1'b1, 1'b1, nc});
          exp_wa.push_back(fdesc + 1);
          exp_wd.push_back(fctrl | USED | EXH);
        end
        break;
      end
      a = mm[d];
      if (!inf) begin fctrl = c; fdesc = d; nc = c[16]; end
      len = int'(c[10:0]);
      for (int i = 0; i < len; i++) begin
        b = int'(a) + i;
        w = mm[(b >> 2) & 1023];
        exp_beat.push_back({8'(w >> (8 * (b % 4))), c[15] && (i == len - 1), 1'b0, nc});
      end
      if (len == 0 && c[15]) exp_beat.push_back({8'h00, 1'b1, 1'b0, nc});
      wd = (c | USED) & ~(UNDR | EXH);
      exp_wa.push_back(d + 1);
      exp_wd.push_back(wd);
      mm[d + 1] = wd;
      inf = !c[15];
      if (c[15]) frames++;
      idx = c[30] ? 0 : idx + 1;
    end
    eidx = idx;
  endtask

  task automatic run(input int maxf, input bit poke_start, input string tag);
    int nidx;
    run_tag = tag;
    model(cur_idx, maxf, nidx);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    #2 chk(busy == 1'b1, {tag, " R1"}, "busy after start", {31'd0, busy}, 1);
    if (poke_start) begin
      repeat (6) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_beat.size() == 0, tag, "beats left", exp_beat.size(), 0);
    chk(exp_wa.size() == 0, tag, "writes left", exp_wa.size(), 0);
    chk(busy == 1'b0 && tx_valid == 1'b0, tag, "stopped quiet",
        {30'd0, busy, tx_valid}, 0);
    cur_idx = nidx;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    chk(busy == 0, "R12", "busy in reset", {31'd0, busy}, 0);
    chk(tx_valid == 0 && mem_en == 0, "R12", "outputs in reset",
        {30'd0, tx_valid, mem_en}, 0);
    rst_n = 1;
    for (int w = 'h100; w < 'h140; w++)
      poke(w, {8'(w * 4 + 3), 8'(w * 4 + 2), 8'(w * 4 + 1), 8'(w * 4)} ^ 32'h5a3c_96e1);
    rand_rdy = 1;
    // R12 R3 R5: from descriptor 0, unaligned buffer, two frames, then stop
    desc(0, 32'h401, EOF | 32'd5);
    desc(1, 32'h480, NOCRC | 32'd6);
    desc(2, 32'h4c3, EOF | 32'd4);
    desc(3, 32'h500, USED);
    run(1000, 0, "R3 R10 R12");
    run(1000, 0, "R7");
    desc(3, 32'h500, EOF | WRAP | 32'd2);
    run(1000, 0, "R6");
    desc(0, 32'h402, EOF | 32'd1);
    run(1000, 0, "R6 R7");
    desc(1, 32'h480, NOCRC | 32'd4);
    run(1000, 0, "R8");
    desc(2, 32'h4a0, 32'd0);
    desc(3, 32'h4a0, EOF | WRAP | NOCRC | 32'd0);
    run(1000, 0, "R11");
    desc(0, 32'h400, EOF | 32'd8);
    desc(1, 32'h420, EOF | NOCRC | 32'd8);
    desc(2, 32'h440, EOF | 32'd8);
    desc(3, 32'h500, USED);
    halt_arm = 1;
    run(1, 0, "R9");
    run(1000, 1, "R9 R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule